// File: doc/BRIEF.md
# Tick-Driven Watchdog Timer

This block is a watchdog peripheral that sits behind a plain synchronous register bus. Software picks a timeout, chooses what happens on expiry, and starts the count. It must then restart the count regularly. An internal prescaler divides the system clock into one-second ticks. A counter advances on those ticks toward a power-of-two limit. If software fails to restart the count in time, the block raises an interrupt, and can also raise a reset request.

The timeout is held as a log2 code in which 3 means one tick, and each step above 3 doubles it. A read-only status flag gives a handshake:
- After a restart, the flag drops and then returns high once the count is running afresh.
- After a disable, the flag falls and stays low, so software knows it is safe to reprogram.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the period register (offset 0x4) reads 9, the reset-select register (offset 0x8) reads 0, the control register (offset 0xC) reads 0, and `irq_o` and `rst_req_o` are low.
- R2: The period code is held in bits [3:0] of offset 0x4. When the watchdog starts with code c, `irq_o` rises exactly 2^(c-3)·TICK_DIV clock cycles after the starting write is accepted.
- R3: Period codes below 3 behave as code 3, and codes above 10 behave as code 10.
- R4: In the control register, bit 0 is enable, bit 1 is clear and bit 8 is status. Bit 0 reads back the enable state. Bit 1 always reads 0. Writes to bit 8 have no effect.
- R5: A start is any of the following control writes:
  - enable=1 together with clear=1;
  - enable=1 while the watchdog is disabled.

  On a start, status reads 0 in the cycle after the write. It reads 1 from two cycles after the write onward.
- R6: A control write with enable=0 stops the watchdog. It clears status, `irq_o` and `rst_req_o`, and holds the count at zero.
- R7: The reset-select value is held in bits [1:0] of offset 0x8. Value 0 makes expiry assert both `irq_o` and `rst_req_o`. Any nonzero value, 2 included, asserts `irq_o` only.
- R8: After expiry, `irq_o` stays high until the next start or stop. A start clears it in the cycle after the write.
- R9: A write to the period register while the watchdog is running does not change the timeout of the count in progress.
- R10: A clear written while the watchdog is disabled does not start it. Status stays 0 and `irq_o` never rises.
- R11: A read from any address other than 0x4, 0x8 or 0xC returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | ADDR_W | Register byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_rdata | output | DATA_W | Combinational read data for `bus_addr` |
| irq_o | output | 1 | Expiry interrupt, held |
| rst_req_o | output | 1 | Expiry reset request, held, only when reset select is 0 |

## Verification
The assertions are checked on every cycle. They cover:
- the status handshake after every start;
- that a stop clears status and both outputs;
- that `irq_o` stays held between control writes;
- that the reset request never appears without the interrupt;
- that an expiry never occurs while the watchdog is disabled.

Some behaviours can be shown only by the bench's scenarios, which count cycles from the start to the interrupt. These are:
- the exact expiry latency for each period code, including the clamped codes;
- that a period write made during a run is ignored;
- that a clear written while disabled leaves the block idle.

// File: rtl/tick_watchdog.sv
module tick_watchdog #(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int TICK_DIV = 50_000_000,
  parameter int PER_DEF  = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq_o,
  output logic              rst_req_o
);
  localparam int PMIN  = 3;
  localparam int PMAX  = 10;
  localparam int CNT_W = PMAX - PMIN + 1;
  localparam int SH_W  = $clog2(CNT_W);
  localparam int PRE_W = $clog2(TICK_DIV + 1);
  localparam logic [ADDR_W-1:0] A_PER = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_SEL = ADDR_W'(8);
  localparam logic [ADDR_W-1:0] A_CTL = ADDR_W'(12);

  logic [3:0]       per_q;
  logic [1:0]       sel_q;
  logic             en_q, stat_q, exp_q;
  logic [1:0]       sh_q;
  logic [SH_W-1:0]  shamt_q;
  logic [CNT_W-1:0] cnt_q;
  logic [PRE_W-1:0] pre_q;
  logic [3:0]       per_clamp;

  wire ctrl_wr = bus_we && (bus_addr == A_CTL);
  wire start   = ctrl_wr && bus_wdata[0] && (bus_wdata[1] || !en_q);
  wire stop    = ctrl_wr && !bus_wdata[0];
  wire tick    = en_q && !exp_q && (pre_q == PRE_W'(TICK_DIV - 1));
  wire [CNT_W-1:0] last = (CNT_W'(1) << shamt_q) - CNT_W'(1);

  always_comb begin
    if (per_q < 4'(PMIN))      per_clamp = 4'(PMIN);
    else if (per_q > 4'(PMAX)) per_clamp = 4'(PMAX);
    else                       per_clamp = per_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      per_q   <= 4'(PER_DEF);
      sel_q   <= '0;
      en_q    <= 1'b0;
      stat_q  <= 1'b0;
      exp_q   <= 1'b0;
      sh_q    <= '0;
      shamt_q <= '0;
      cnt_q   <= '0;
      pre_q   <= '0;
    end else begin
      if (bus_we && bus_addr == A_PER) per_q <= bus_wdata[3:0];
      if (bus_we && bus_addr == A_SEL) sel_q <= bus_wdata[1:0];
      if (ctrl_wr) en_q <= bus_wdata[0];
      if (start) begin
        shamt_q <= SH_W'(per_clamp - 4'(PMIN));
        cnt_q   <= '0;
        pre_q   <= '0;
        exp_q   <= 1'b0;
        stat_q  <= 1'b0;
        sh_q    <= 2'b01;
      end else if (stop) begin
        cnt_q  <= '0;
        pre_q  <= '0;
        exp_q  <= 1'b0;
        stat_q <= 1'b0;
        sh_q   <= '0;
      end else if (en_q) begin
        sh_q <= {sh_q[0], 1'b0};
        if (sh_q[1]) stat_q <= 1'b1;
        if (!exp_q) begin
          pre_q <= tick ? '0 : pre_q + 1'b1;
          if (tick) begin
            if (cnt_q == last) exp_q <= 1'b1;
            else               cnt_q <= cnt_q + 1'b1;
          end
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      A_PER: bus_rdata[3:0] = per_q;
      A_SEL: bus_rdata[1:0] = sel_q;
      A_CTL: begin
        bus_rdata[0] = en_q;
        bus_rdata[8] = stat_q;
      end
      default: bus_rdata = '0;
    endcase
  end

  assign irq_o     = exp_q;
  assign rst_req_o = exp_q && (sel_q == 2'd0);
endmodule

// File: rtl/tick_watchdog_chk.sv
module tick_watchdog_chk #(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic              bus_we,
  input logic              en,
  input logic              stat,
  input logic              irq_o,
  input logic              rst_req_o
);
  wire cw  = bus_we && (bus_addr == ADDR_W'(12));
  wire go  = cw && bus_wdata[0] && (bus_wdata[1] || !en);
  wire off = cw && !bus_wdata[0];

  p_status_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go |=> !stat);
  p_status_rise_r5: assert property (@(posedge clk) disable iff (!rst_n)
    go ##1 !cw ##1 !cw |=> stat);
  p_stop_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
    off |=> (!stat && !irq_o && !rst_req_o));
  p_rst_with_irq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req_o |-> irq_o);
  p_irq_held_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_o && !cw) |=> irq_o);
  p_irq_needs_en_r4: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> en);
endmodule

bind tick_watchdog tick_watchdog_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
  .bus_we(bus_we), .en(en_q), .stat(stat_q), .irq_o(irq_o), .rst_req_o(rst_req_o)
);

// File: tb/tick_watchdog_bench.sv
module tick_watchdog_bench;
  localparam int CLK_PERIOD = 10;
  localparam int TD = 4;
  localparam int NV = 7;
  // {code[3:0], sel[1:0], cycles[15:0], rst[0]}
  localparam logic [22:0] VEC [NV] = '{
    {4'd3,  2'd0, 16'd4,   1'b1},
    {4'd4,  2'd2, 16'd8,   1'b0},
    {4'd6,  2'd0, 16'd32,  1'b1},
    {4'd10, 2'd2, 16'd512, 1'b0},
    {4'd15, 2'd0, 16'd512, 1'b1},
    {4'd0,  2'd2, 16'd4,   1'b0},
    {4'd7,  2'd1, 16'd64,  1'b0}
  };

  logic clk = 0, rst_n = 0, bus_we = 0;
  logic [3:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic irq_o, rst_req_o;
  int n_run = 0, n_fail = 0;

  tick_watchdog #(.TICK_DIV(TD)) u_tick_watchdog (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_we(bus_we), .bus_rdata(bus_rdata), .irq_o(irq_o), .rst_req_o(rst_req_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [3:0] a, logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
  endtask

  task automatic rd(logic [3:0] a, output logic [31:0] d);
    bus_addr = a; #1 d = bus_rdata;
  endtask

  task automatic wait_irq(int first, output int n);
    n = first;
    while (!irq_o && n < 700) begin
      @(posedge clk); #1 n++;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    n_fail++; n_run++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    int n;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    rd(4'h4, d); chk("R1 period reset", d, 9);
    rd(4'h8, d); chk("R1 sel reset", d, 0);
    rd(4'hC, d); chk("R1 ctrl reset", d, 0);
    chk("R1 irq reset", irq_o, 0);
    chk("R1 rst reset", rst_req_o, 0);
    rd(4'h0, d); chk("R11 unmapped 0x0", d, 0);
    wr(4'h2, 32'hFFFF_FFFF);
    rd(4'h2, d); chk("R11 unmapped 0x2", d, 0);

    for (int i = 0; i < NV; i++) begin
      wr(4'h4, 32'(VEC[i][22:19]));
      wr(4'h8, 32'(VEC[i][18:17]));
      wr(4'hC, 32'h3);
      wait_irq(0, n);
      chk("R2/R3 expiry cycles", n, 32'(VEC[i][16:1]));
      chk("R7 reset request", rst_req_o, VEC[i][0]);
      repeat (3) @(posedge clk);
      #1 chk("R8 irq held", irq_o, 1);
      wr(4'hC, 32'h0);
      chk("R6 irq off", irq_o, 0);
      chk("R6 rst off", rst_req_o, 0);
    end

    // status handshake
    wr(4'h8, 0); wr(4'h4, 3);
    wr(4'hC, 32'h103);
    rd(4'hC, d); chk("R4 ctrl readback", d, 1);
    chk("R5 status low after start", d[8], 0);
    @(posedge clk); #1 rd(4'hC, d); chk("R5 status low +1", d[8], 0);
    @(posedge clk); #1 rd(4'hC, d); chk("R5 status high +2", d[8], 1);
    wait_irq(2, n); chk("R8 expiry before restart", irq_o, 1);
    wr(4'hC, 32'h3);
    chk("R8 restart clears irq", irq_o, 0);
    wr(4'hC, 32'h0);
    rd(4'hC, d); chk("R6 status low after stop", d, 0);

    // period write during run, enable-only start
    wr(4'h4, 3);
    wr(4'hC, 32'h1);
    @(negedge clk); bus_addr = 4'h4; bus_wdata = 10; bus_we = 1;
    @(posedge clk); #1 bus_we = 0;
    wait_irq(1, n); chk("R9 running period kept", n, 4);
    rd(4'h4, d); chk("R9 period reg updated", d, 10);
    wr(4'hC, 32'h0);

    // clear while disabled
    wr(4'h4, 3);
    wr(4'hC, 32'h2);
    repeat (12) @(posedge clk);
    #1 chk("R10 no irq", irq_o, 0);
    rd(4'hC, d); chk("R10 ctrl idle", d, 0);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule